// File: doc/BRIEF.md
# DMA Queue Request Arbiter

This block sits between the six memory-service queues of a network controller's DMA engine and the controller that runs transfers on the system bus. Every queue can ask for service in two ways: an urgent request, raised when the queue is about to stall, and a relaxed request, raised when it merely has work ready. The arbiter picks one queue at a time. It reports the queue index, the direction of the transfer and whether the win came from the urgent tier. It holds that grant until the bus side returns a one-cycle completion pulse.

The six queues and their index codes are fixed. Receive frame data (0), receive frame status (1) and transmit completion status (3) move data into memory. Transmit frame data (2), receive descriptor fetch (4) and transmit descriptor fetch (5) move data out of memory. Descriptor fetches are raised inside the DMA engine, and they compete on equal terms with the data and status queues.

Ranking has three steps. Urgency is decided first. Among requests of the same urgency, memory writes come before memory reads, so that a finished write does not hold back the next one. Among requests that are still tied, a rotating pointer is used, and it moves to the index just after the last winner.

Top module: `qarb_top`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, gnt_valid, gnt_idx, gnt_write and gnt_urgent are all 0.
- R2: When no urgent or relaxed request is asserted in an idle cycle, gnt_valid stays 0 in the next cycle.
- R3: If any urgent request is asserted in an idle cycle, the grant that follows goes to a queue whose urgent line was set, with gnt_urgent = 1; otherwise gnt_urgent = 0.
- R4: Within the winning urgency tier, a write-direction queue is granted whenever one is requesting, ahead of every read-direction queue.
- R5: Among tied requesters, the winner is the first requesting index found by counting upward, wrapping from 5 to 0, starting at one past the previous winner. After reset the count starts at index 0.
- R6: While gnt_valid is 1 and done is 0, gnt_idx, gnt_write and gnt_urgent hold their values, whatever the request lines do.
- R7: done = 1 while gnt_valid is 1 clears gnt_valid in the next cycle. A new grant, if any request is pending, appears one cycle after that.
- R8: A done pulse while gnt_valid is 0 has no effect.
- R9: gnt_write is 1 for queue codes 0, 1 and 3 and 0 for codes 2, 4 and 5.
- R10: gnt_idx carries the queue code: 0 receive data, 1 receive status, 2 transmit data, 3 transmit status, 4 receive descriptor, 5 transmit descriptor. It never exceeds 5 while gnt_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hard_req | input | 6 | Urgent request, one bit per queue code |
| soft_req | input | 6 | Relaxed request, one bit per queue code |
| done | input | 1 | One-cycle completion pulse from the bus side |
| gnt_valid | output | 1 | A grant is being held |
| gnt_idx | output | 3 | Code of the granted queue |
| gnt_write | output | 1 | 1 = memory write, 0 = memory read |
| gnt_urgent | output | 1 | 1 = grant came from the urgent tier |

## Verification
The assertions take for granted that the request lines and done carry known values from the end of reset onward. They also assume that done is a single-cycle pulse, so one pulse releases exactly one grant. They do not assume that a requester keeps its line raised. The stimulus therefore changes the request lines freely while a grant is held, in order to test the hold rule. It drives done only as isolated one-cycle pulses, and it fires some of those pulses on purpose while the arbiter is idle.

// File: rtl/qarb_pkg.sv
package qarb_pkg;
   localparam int QARB_NQ = 6;
   // bit set = queue moves data into memory
   localparam logic [QARB_NQ-1:0] QARB_WR_MAP = 6'b001011;

   typedef enum logic [1:0] {
      CLS_URG_WR = 2'd0,
      CLS_URG_RD = 2'd1,
      CLS_REL_WR = 2'd2,
      CLS_REL_RD = 2'd3
   } qarb_cls_e;
endpackage

// File: rtl/qarb_class_sel.sv
module qarb_class_sel #(
   parameter int NUM_Q = 6,
   parameter logic [NUM_Q-1:0] WR_MASK = '0
) (
   input  logic [NUM_Q-1:0] hard_req,
   input  logic [NUM_Q-1:0] soft_req,
   output logic [NUM_Q-1:0] cand,
   output logic             any_req,
   output logic             cls_urgent,
   output logic             cls_write
);
   import qarb_pkg::*;

   logic [NUM_Q-1:0] urg_wr, urg_rd, rel_wr, rel_rd;
   qarb_cls_e cls;

   assign urg_wr = hard_req & WR_MASK;
   assign urg_rd = hard_req & ~WR_MASK;
   assign rel_wr = soft_req & WR_MASK;
   assign rel_rd = soft_req & ~WR_MASK;

   always_comb begin
      if (|urg_wr)      cls = CLS_URG_WR;
      else if (|urg_rd) cls = CLS_URG_RD;
      else if (|rel_wr) cls = CLS_REL_WR;
      else              cls = CLS_REL_RD;
   end

   always_comb begin
      unique case (cls)
         CLS_URG_WR: cand = urg_wr;
         CLS_URG_RD: cand = urg_rd;
         CLS_REL_WR: cand = rel_wr;
         default:    cand = rel_rd;
      endcase
   end

   assign any_req    = |(hard_req | soft_req);
   assign cls_urgent = (cls == CLS_URG_WR) || (cls == CLS_URG_RD);
   assign cls_write  = (cls == CLS_URG_WR) || (cls == CLS_REL_WR);
endmodule

// File: rtl/qarb_rr_pick.sv
module qarb_rr_pick #(
   parameter int NUM_Q = 6,
   parameter int IDX_W = 3,
   parameter bit RR_EN = 1'b1
) (
   input  logic [NUM_Q-1:0] cand,
   input  logic [IDX_W-1:0] start,
   output logic             hit,
   output logic [IDX_W-1:0] win
);
   generate
      if (RR_EN) begin : g_rotate
         always_comb begin
            hit = 1'b0;
            win = '0;
            for (int k = 0; k < NUM_Q; k++) begin
               int p;
               p = int'(start) + k;
               if (p >= NUM_Q) p = p - NUM_Q;
               if (!hit && cand[p]) begin
                  hit = 1'b1;
                  win = IDX_W'(p);
               end
            end
         end
      end else begin : g_fixed
         always_comb begin
            hit = 1'b0;
            win = '0;
            for (int k = 0; k < NUM_Q; k++) begin
               if (!hit && cand[k]) begin
                  hit = 1'b1;
                  win = IDX_W'(k);
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/qarb_grant_reg.sv
module qarb_grant_reg #(
   parameter int NUM_Q = 6,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done,
   input  logic             arb_hit,
   input  logic [IDX_W-1:0] arb_idx,
   input  logic             arb_write,
   input  logic             arb_urgent,
   output logic             gnt_valid,
   output logic [IDX_W-1:0] gnt_idx,
   output logic             gnt_write,
   output logic             gnt_urgent,
   output logic [IDX_W-1:0] rr_ptr
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_Q - 1);

   logic launch;
   assign launch = !gnt_valid && arb_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gnt_valid  <= 1'b0;
         gnt_idx    <= '0;
         gnt_write  <= 1'b0;
         gnt_urgent <= 1'b0;
         rr_ptr     <= '0;
      end else if (gnt_valid) begin
         if (done) gnt_valid <= 1'b0;
      end else if (launch) begin
         gnt_valid  <= 1'b1;
         gnt_idx    <= arb_idx;
         gnt_write  <= arb_write;
         gnt_urgent <= arb_urgent;
         rr_ptr     <= (arb_idx == LAST_IDX) ? '0 : arb_idx + 1'b1;
      end
   end
endmodule

// File: rtl/qarb_top.sv
module qarb_top #(
   parameter int NUM_Q = qarb_pkg::QARB_NQ,
   parameter logic [NUM_Q-1:0] WR_MASK = qarb_pkg::QARB_WR_MAP,
   parameter bit RR_EN = 1'b1,
   localparam int IDX_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NUM_Q-1:0] hard_req,
   input  logic [NUM_Q-1:0] soft_req,
   input  logic             done,
   output logic             gnt_valid,
   output logic [IDX_W-1:0] gnt_idx,
   output logic             gnt_write,
   output logic             gnt_urgent
);
   generate
      if (NUM_Q < 2) begin : g_chk_nq
         $error("qarb_top: NUM_Q must be at least 2");
      end
      if (NUM_Q > (1 << IDX_W)) begin : g_chk_iw
         $error("qarb_top: index width too narrow");
      end
   endgenerate

   logic [NUM_Q-1:0] cand;
   logic             any_req, cls_urgent, cls_write;
   logic             hit;
   logic [IDX_W-1:0] win, rr_ptr;

   qarb_class_sel #(.NUM_Q(NUM_Q), .WR_MASK(WR_MASK)) u_cls (
      .hard_req   (hard_req),
      .soft_req   (soft_req),
      .cand       (cand),
      .any_req    (any_req),
      .cls_urgent (cls_urgent),
      .cls_write  (cls_write)
   );

   qarb_rr_pick #(.NUM_Q(NUM_Q), .IDX_W(IDX_W), .RR_EN(RR_EN)) u_pick (
      .cand  (cand),
      .start (rr_ptr),
      .hit   (hit),
      .win   (win)
   );

   qarb_grant_reg #(.NUM_Q(NUM_Q), .IDX_W(IDX_W)) u_gnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .done       (done),
      .arb_hit    (hit && any_req),
      .arb_idx    (win),
      .arb_write  (cls_write),
      .arb_urgent (cls_urgent),
      .gnt_valid  (gnt_valid),
      .gnt_idx    (gnt_idx),
      .gnt_write  (gnt_write),
      .gnt_urgent (gnt_urgent),
      .rr_ptr     (rr_ptr)
   );
endmodule

// File: rtl/qarb_checker.sv
module qarb_checker #(
   parameter int NUM_Q = 6,
   parameter int IDX_W = 3,
   parameter logic [NUM_Q-1:0] WR_MASK = '0
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NUM_Q-1:0] hard_req,
   input logic [NUM_Q-1:0] soft_req,
   input logic             done,
   input logic             gnt_valid,
   input logic [IDX_W-1:0] gnt_idx,
   input logic             gnt_write,
   input logic             gnt_urgent
);
   AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (!gnt_valid && hard_req == '0 && soft_req == '0) |=> !gnt_valid); // R2
   AST_URGENT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (!gnt_valid && hard_req != '0) |=> (gnt_valid && gnt_urgent)); // R3
   AST_WRITE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (!gnt_valid && (hard_req & WR_MASK) != '0) |=> gnt_write); // R4
   AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_valid && !done) |=> (gnt_valid && $stable(gnt_idx) &&
                                $stable(gnt_write) && $stable(gnt_urgent))); // R6
   AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_valid && done) |=> !gnt_valid); // R7
   AST_DIR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid |-> (gnt_write == WR_MASK[gnt_idx])); // R9
   AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid |-> (int'(gnt_idx) < NUM_Q)); // R10
endmodule

bind qarb_top qarb_checker #(.NUM_Q(NUM_Q), .IDX_W(IDX_W), .WR_MASK(WR_MASK)) u_qarb_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .hard_req   (hard_req),
   .soft_req   (soft_req),
   .done       (done),
   .gnt_valid  (gnt_valid),
   .gnt_idx    (gnt_idx),
   .gnt_write  (gnt_write),
   .gnt_urgent (gnt_urgent)
);

// File: tb/qarb_top_bench.sv
module qarb_top_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] hard_req = '0;
   logic [5:0] soft_req = '0;
   logic       done = 1'b0;
   logic       gnt_valid;
   logic [2:0] gnt_idx;
   logic       gnt_write;
   logic       gnt_urgent;

   int n_cmp = 0;
   int n_bad = 0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   qarb_top u_qarb_top (
      .clk(clk), .rst_n(rst_n), .hard_req(hard_req), .soft_req(soft_req),
      .done(done), .gnt_valid(gnt_valid), .gnt_idx(gnt_idx),
      .gnt_write(gnt_write), .gnt_urgent(gnt_urgent)
   );

   // reference model: write queues are codes 0,1,3
   function automatic bit is_wr(int q);
      return (q == 0) || (q == 1) || (q == 3);
   endfunction

   int m_valid, m_idx, m_wr, m_urg, m_ptr;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_valid = 0; m_idx = 0; m_wr = 0; m_urg = 0; m_ptr = 0;
      end else if (m_valid != 0) begin
         if (done) m_valid = 0;
      end else begin
         int best_key, best_q;
         best_key = 1000; best_q = -1;
         for (int q = 0; q < 6; q++) begin
            int tier, key;
            if (hard_req[q]) tier = 0;
            else if (soft_req[q]) tier = 1;
            else continue;
            key = (tier * 2 + (is_wr(q) ? 0 : 1)) * 8 + ((q - m_ptr + 6) % 6);
            if (key < best_key) begin best_key = key; best_q = q; end
         end
         if (best_q >= 0) begin
            m_valid = 1; m_idx = best_q; m_wr = is_wr(best_q) ? 1 : 0;
            m_urg = hard_req[best_q] ? 1 : 0; m_ptr = (best_q + 1) % 6;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         n_cmp++;
         if (int'(gnt_valid) != m_valid ||
             (m_valid != 0 && (int'(gnt_idx) != m_idx || int'(gnt_write) != m_wr ||
                               int'(gnt_urgent) != m_urg))) begin
            n_bad++;
            $display("FAIL %s: got v=%0d i=%0d w=%0d u=%0d exp v=%0d i=%0d w=%0d u=%0d",
                     cur_req, gnt_valid, gnt_idx, gnt_write, gnt_urgent,
                     m_valid, m_idx, m_wr, m_urg);
         end
      end
   end

   task automatic chk(string tag, int v, int i, int w, int u);
      n_cmp++;
      if (int'(gnt_valid) != v || (v != 0 && (int'(gnt_idx) != i ||
          int'(gnt_write) != w || int'(gnt_urgent) != u))) begin
         n_bad++;
         $display("FAIL %s: got v=%0d i=%0d w=%0d u=%0d exp v=%0d i=%0d w=%0d u=%0d",
                  tag, gnt_valid, gnt_idx, gnt_write, gnt_urgent, v, i, w, u);
      end
   endtask

   task automatic pulse_done();
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
   endtask

   initial begin
      #200000;
      n_bad++;
      $display("FAIL watchdog: got hang exp finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 in reset", 0, 0, 0, 0);
      n_cmp++;
      if (gnt_idx != 3'd0 || gnt_write || gnt_urgent) begin
         n_bad++;
         $display("FAIL R1: got i=%0d w=%0d u=%0d exp 0 0 0", gnt_idx, gnt_write, gnt_urgent);
      end
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset", 0, 0, 0, 0);

      cur_req = "R2";
      repeat (3) @(negedge clk);
      chk("R2 idle", 0, 0, 0, 0);

      cur_req = "R8";
      pulse_done();
      chk("R8 done while idle", 0, 0, 0, 0);

      cur_req = "R3";
      hard_req = 6'b000100; soft_req = 6'b000001;
      @(negedge clk);
      chk("R3 urgent read beats relaxed write", 1, 2, 0, 1);

      cur_req = "R6";
      hard_req = 6'b000000; soft_req = 6'b100000;
      repeat (2) @(negedge clk);
      chk("R6 hold through request change", 1, 2, 0, 1);

      cur_req = "R7";
      pulse_done();
      chk("R7 released after done", 0, 0, 0, 0);
      @(negedge clk);
      chk("R7 regrant one cycle later", 1, 5, 0, 0);

      cur_req = "R4";
      soft_req = 6'b011100;
      pulse_done();
      @(negedge clk);
      chk("R4 write beats reads", 1, 3, 1, 0);

      cur_req = "R5";
      soft_req = 6'b001011;
      pulse_done();
      @(negedge clk);
      chk("R5 rotate from 4 to 0", 1, 0, 1, 0);
      pulse_done();
      @(negedge clk);
      chk("R5 rotate to 1", 1, 1, 1, 0);
      pulse_done();
      @(negedge clk);
      chk("R5 rotate to 3", 1, 3, 1, 0);

      cur_req = "R9";
      hard_req = 6'b100000; soft_req = 6'b000011;
      pulse_done();
      @(negedge clk);
      chk("R9 R10 code 5 is read", 1, 5, 0, 1);
      hard_req = 6'b000010; soft_req = 6'b0;
      pulse_done();
      @(negedge clk);
      chk("R9 R10 code 1 is write", 1, 1, 1, 1);

      cur_req = "R5 random";
      hard_req = '0;
      pulse_done();
      for (int n = 0; n < 4000; n++) begin
         hard_req = ($urandom_range(0, 3) == 0) ? 6'($urandom) : 6'b0;
         soft_req = 6'($urandom);
         if ($urandom_range(0, 2) == 0) pulse_done();
         else @(negedge clk);
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule